// File: doc/BRIEF.md
# Link-Speed Transmit Throttle

This block sits beside a transmit frame generator whose clock runs at one fixed rate whatever the real line rate is. A slower link is served by holding off the next frame: the block measures how long the generator was active on the previous frame, and after that activity ends it keeps a throttled busy flag raised for that duration times a stretch factor. The stretch factor follows from a 3-bit link-speed code. The upstream buffer uses the throttled busy in place of the generator's own busy, so no new frame starts until the line has had time to drain the previous one.

The generator is counted as active while either its busy flag or its own gap flag is high. The throttle only ever lengthens gaps; it never shortens them. A speed code chosen lower than the real link costs throughput but keeps data intact. A code chosen higher than the real link can lose or cut frames.

Top module: `link_tx_throttle`

## Requirements
- R1: In the cycle after a synchronous reset, thr_busy is 0 when gen_busy and gen_gap are both low. A reset also cancels any hold-off in progress.
- R2: thr_busy is 1 in every cycle in which gen_busy or gen_gap is 1.
- R3: Let N be the number of consecutive cycles in which gen_busy or gen_gap was high. After that activity ends, thr_busy stays 1 for exactly N*(ratio-1) cycles and then goes to 0.
- R4: The speed code sets the ratio as follows: 3'b000 is 1 (10 Gb/s), 3'b001 is 2 (5 Gb/s), 3'b010 is 4 (2.5 Gb/s), 3'b011 is 10 (1 Gb/s), 3'b100 is 100 (100 Mb/s) and 3'b101 is 1000 (10 Mb/s).
- R5: Codes 3'b110 and 3'b111 act as ratio 1, so no hold-off follows the activity.
- R6: The speed code is sampled in the first active cycle of a frame. Changing it later in that frame, or during the hold-off that follows, does not alter that hold-off. The new code applies from the next frame.
- R7: The active-cycle count N saturates at 2^CW-1 instead of wrapping, where CW = $clog2(MAX_FRAME_CYC+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole block |
| rst | input | 1 | Synchronous reset, active high |
| speed_code | input | 3 | Encoded link speed (see R4, R5) |
| gen_busy | input | 1 | Frame generator is sending a frame |
| gen_gap | input | 1 | Frame generator is sending its own inter-frame gap |
| thr_busy | output | 1 | Throttled busy that gates the start of the next frame |

## Verification
The bench builds the block with MAX_FRAME_CYC = 15, so the active-cycle counter is 4 bits wide and saturates at 15. A frame of 18 or 20 cycles is therefore enough to show that the counter clamps without wrapping. With the ratio-1000 code, even the saturated count gives a hold-off of 14985 cycles, which fits easily in the run. The default MAX_FRAME_CYC of 1200 only widens the counters, so the same timing relations hold at full size.

// File: rtl/lst_pkg.sv
package lst_pkg;

  localparam int FACTOR_W = 10;

  typedef enum logic [2:0] {
    SPD_10G  = 3'd0,
    SPD_5G   = 3'd1,
    SPD_2G5  = 3'd2,
    SPD_1G   = 3'd3,
    SPD_100M = 3'd4,
    SPD_10M  = 3'd5
  } spd_e;

  // Extra gap cycles per active cycle (ratio - 1)
  function automatic logic [FACTOR_W-1:0] gap_factor(input logic [2:0] code);
    case (code)
      SPD_5G:   gap_factor = FACTOR_W'(1);
      SPD_2G5:  gap_factor = FACTOR_W'(3);
      SPD_1G:   gap_factor = FACTOR_W'(9);
      SPD_100M: gap_factor = FACTOR_W'(99);
      SPD_10M:  gap_factor = FACTOR_W'(999);
      default:  gap_factor = '0;
    endcase
  endfunction

endpackage

// File: rtl/lst_frame_meter.sv
module lst_frame_meter
  import lst_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                active,
  input  logic [2:0]          speed_code,
  output logic                fall,
  output logic [CNT_W-1:0]    cnt,
  output logic [FACTOR_W-1:0] factor
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic active_q;
  logic start;

  assign start = active & ~active_q;
  assign fall  = active_q & ~active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt      <= '0;
      factor   <= '0;
    end else begin
      active_q <= active;
      if (start) begin
        cnt    <= CNT_W'(1);
        factor <= gap_factor(speed_code);
      end else if (active && cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && active && active_q) |=> (cnt == CNT_MAX));

  // R6
  factor_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(factor));

endmodule

// File: rtl/lst_gap_timer.sv
module lst_gap_timer
  import lst_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int HOLD_W = CNT_W + FACTOR_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fall,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [FACTOR_W-1:0] factor,
  output logic                gap_busy
);

  logic [HOLD_W-1:0] prod;
  logic [HOLD_W-1:0] hold;
  logic              load;

  assign prod     = HOLD_W'(cnt) * HOLD_W'(factor);
  assign load     = fall && (prod != '0);
  assign gap_busy = load || (hold != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
    end else if (load) begin
      hold <= prod - 1'b1;
    end else if (hold != '0) begin
      hold <= hold - 1'b1;
    end
  end

  // R3
  hold_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (hold != '0 && !fall) |=> (hold == $past(hold) - 1'b1));

  // R3
  hold_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (hold != '0 && $past(hold) == '0) |-> $past(fall));

  // R5
  zero_factor_chk: assert property (@(posedge clk) disable iff (rst)
    (fall && factor == '0) |-> !gap_busy || (hold != '0));

endmodule

// File: rtl/link_tx_throttle.sv
module link_tx_throttle
  import lst_pkg::*;
#(
  parameter int MAX_FRAME_CYC = 1200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] speed_code,
  input  logic       gen_busy,
  input  logic       gen_gap,
  output logic       thr_busy
);

  localparam int CNT_W  = $clog2(MAX_FRAME_CYC + 1);
  localparam int HOLD_W = CNT_W + FACTOR_W;

  logic                active;
  logic                fall;
  logic [CNT_W-1:0]    cnt;
  logic [FACTOR_W-1:0] factor;
  logic                gap_busy;

  assign active = gen_busy | gen_gap;

  lst_frame_meter #(.CNT_W(CNT_W)) u_meter (
    .clk        (clk),
    .rst        (rst),
    .active     (active),
    .speed_code (speed_code),
    .fall       (fall),
    .cnt        (cnt),
    .factor     (factor)
  );

  lst_gap_timer #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .fall     (fall),
    .cnt      (cnt),
    .factor   (factor),
    .gap_busy (gap_busy)
  );

  assign thr_busy = active | gap_busy;

  // R2
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_busy || gen_gap) |-> thr_busy);

  // R3
  release_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(thr_busy) |-> !gen_busy && !gen_gap);

endmodule

// File: tb/tb_link_tx_throttle.sv
module tb_link_tx_throttle;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] speed_code = 3'd0;
  logic       gen_busy = 1'b0;
  logic       gen_gap = 1'b0;
  logic       thr_busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  link_tx_throttle #(.MAX_FRAME_CYC(15)) dut (
    .clk        (clk),
    .rst        (rst),
    .speed_code (speed_code),
    .gen_busy   (gen_busy),
    .gen_gap    (gen_gap),
    .thr_busy   (thr_busy)
  );

  localparam int NV = 13;
  localparam int T_CODE [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 1, 2, 3, 5, 4};
  localparam int T_NB   [NV] = '{5, 5, 3, 4, 2, 1, 6, 3, 0, 20, 18, 12, 1};
  localparam int T_NG   [NV] = '{2, 2, 1, 0, 1, 0, 1, 3, 3, 0, 2, 3, 0};
  localparam int T_EXP  [NV] = '{0, 7, 12, 36, 297, 999, 0, 0, 3, 45, 135, 14985, 99};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one frame from a negedge; ends at the negedge where activity drops.
  task automatic drive_frame(input int nb, input int ng, input int code_mid);
    for (int i = 0; i < nb + ng; i++) begin
      gen_busy = (i < nb);
      gen_gap  = (i >= nb);
      if (i == 1 && code_mid >= 0) speed_code = 3'(code_mid);
      #1;
      chk(thr_busy == 1'b1, "R2 busy during activity", int'(thr_busy), 1);
      @(negedge clk);
    end
    gen_busy = 1'b0;
    gen_gap  = 1'b0;
  endtask

  // Count held cycles after activity ends; optional code change mid-hold.
  task automatic measure(output int held, input int code_hold);
    held = 0;
    while (held < 20000) begin
      #1;
      if (!thr_busy) break;
      held++;
      if (held == 2 && code_hold >= 0) speed_code = 3'(code_hold);
      @(negedge clk);
    end
  endtask

  initial begin
    int held;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: idle after reset
    chk(thr_busy == 1'b0, "R1 reset state", int'(thr_busy), 0);
    @(negedge clk);

    // Table: R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      speed_code = 3'(T_CODE[v]);
      drive_frame(T_NB[v], T_NG[v], -1);
      measure(held, -1);
      chk(held == T_EXP[v], "R3/R4/R5/R7 hold length", held, T_EXP[v]);
      repeat (3) @(negedge clk);
    end

    // R6: code changed mid-frame and mid-hold
    speed_code = 3'd1;
    drive_frame(4, 0, 5);
    measure(held, 0);
    chk(held == 4, "R6 code sampled at frame start", held, 4);
    repeat (2) @(negedge clk);
    speed_code = 3'd5;
    drive_frame(2, 0, -1);
    measure(held, -1);
    chk(held == 1998, "R6 new code from next frame", held, 1998);
    repeat (2) @(negedge clk);

    // R1: reset cancels hold-off
    speed_code = 3'd4;
    drive_frame(3, 0, -1);
    repeat (5) @(negedge clk);
    #1;
    chk(thr_busy == 1'b1, "R3 holding before reset", int'(thr_busy), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(thr_busy == 1'b0, "R1 reset cancels hold", int'(thr_busy), 0);
    @(negedge clk);

    // R5: code 7 after reset, frame with no hold
    speed_code = 3'd7;
    drive_frame(9, 1, -1);
    #1;
    chk(thr_busy == 1'b0, "R5 code 7 no hold", int'(thr_busy), 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule